// File: doc/BRIEF.md
# Cycle Timestamp Counter

This block is a 64-bit cycle counter read by software through a simple memory-mapped port. The port has a write strobe, a read strobe, a one-bit half select and 32-bit data. Software sees the count as two read-only 32-bit windows: the lower half and the upper half.

After reset the counter is idle and holds zero. The first write to the lower-half window arms it. From then on it adds one on every clock cycle, and software has no way to stop it or clear it. Only reset or the power-down input returns it to the idle, zero state. When software reads the lower half, the block copies the upper half into a shadow register. A later read of the upper half returns that copy, so the two reads together form one consistent 64-bit sample.

Read data is registered. It appears one cycle after the read strobe and then holds until the next read.

Top module: `cycle_stamp_counter`

## Requirements
- R1: After reset, and until the block is armed, every read of either half returns zero.
- R2: A write with `bus_sel`=0 (lower half) while `pwr_down` is low arms the counter. A lower-half read in the cycle right after that write returns 0. After that, the count rises by exactly one per clock cycle.
- R3: The value on `bus_wdata` has no effect. A write of 0 arms the counter exactly as a write of all ones does.
- R4: A lower-half write that arrives while the counter is already running does not clear it or restart it.
- R5: A write with `bus_sel`=1 (upper half) changes neither the count nor the armed state.
- R6: While `pwr_down` is high, the counter is disarmed and held at zero, and lower-half writes do not arm it. Arming again after power-down starts the count from zero.
- R7: A lower-half read (`bus_sel`=0) returns count bits [31:0] and stores count bits [63:32] in a shadow register. An upper-half read (`bus_sel`=1) returns that shadow register, not the live upper count.
- R8: `bus_rdata` takes the read result on the clock edge that samples `bus_rd`. It holds that value while no read is issued.
- R9: The count wraps from all ones to zero and keeps counting.
- R10: Asserting `rst_n` low clears the count, the armed state, the shadow and `bus_rdata` at once. They stay cleared for two cycles after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_down | input | 1 | High disarms the counter and holds it at zero |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_sel | input | 1 | Half select: 0 = lower 32 bits, 1 = upper 32 bits |
| bus_wdata | input | 32 | Write data, ignored |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench issues a read strobe between two rising edges. The result is due at `bus_rdata` right after the next rising edge. The monitor compares it at the following falling edge, half a cycle later. On that same edge the bench's reference model records the expected value, built from the count it had before the edge, and then advances its own count. The model therefore treats arming as taking effect one edge after the write, so the first read returns zero.

Power-down and reset act on the very next edge. The bench waits three cycles after reset release before it drives any stimulus, so the two-stage reset release never overlaps an access.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cs_arm_ctrl.sv
module cs_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic arm_req,
  output logic run_q
);
  logic run_d;

  always_comb begin
    run_d = run_q;
    if (pwr_down)     run_d = 1'b0;
    else if (arm_req) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/cs_count_core.sv
module cs_count_core #(
  parameter int CNT_W = 64,
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwr_down,
  output logic [CNT_W-1:0] count_q
);
  localparam int NSEG = CNT_W / SEG_W;

  logic [NSEG:0]      carry;
  logic [CNT_W-1:0]   count_d;
  logic               clear;

  assign clear    = pwr_down | ~run;
  assign carry[0] = run;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg_q;
    logic [SEG_W-1:0] seg_d;

    assign seg_q        = count_q[s*SEG_W +: SEG_W];
    assign carry[s+1]   = carry[s] & (&seg_q);

    always_comb begin
      if (clear) seg_d = '0;
      else       seg_d = seg_q + {{(SEG_W-1){1'b0}}, carry[s]};
    end

    assign count_d[s*SEG_W +: SEG_W] = seg_d;
  end

  logic unused_top_carry;
  assign unused_top_carry = carry[NSEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/cs_read_port.sv
module cs_read_port #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               sel_hi,
  input  logic [2*BUS_W-1:0] count,
  output logic [BUS_W-1:0]   rdata_q,
  output logic [BUS_W-1:0]   shadow_q
);
  logic [BUS_W-1:0] rdata_d;
  logic [BUS_W-1:0] shadow_d;
  logic             shadow_en;

  assign shadow_en = rd_en & ~sel_hi;

  always_comb begin
    shadow_d = shadow_q;
    if (shadow_en) shadow_d = count[2*BUS_W-1:BUS_W];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = sel_hi ? shadow_q : count[BUS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else begin
      rdata_q  <= rdata_d;
      shadow_q <= shadow_d;
    end
  end
endmodule

// File: rtl/cycle_stamp_counter.sv
module cycle_stamp_counter
  import cs_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * BUS_W;

  logic             rst_sync_n;
  logic             run_q;
  logic             arm_req;
  logic             sel_hi;
  logic [CNT_W-1:0] count_q;
  logic [BUS_W-1:0] shadow_q;
  half_sel_e        sel_e;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  assign sel_e   = half_sel_e'(bus_sel);
  assign sel_hi  = (sel_e == HALF_HI);
  assign arm_req = bus_wr & (sel_e == HALF_LO);

  cs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cs_arm_ctrl u_arm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_down (pwr_down),
    .arm_req  (arm_req),
    .run_q    (run_q)
  );

  cs_count_core #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_q),
    .pwr_down (pwr_down),
    .count_q  (count_q)
  );

  cs_read_port #(.BUS_W(BUS_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (bus_rd),
    .sel_hi   (sel_hi),
    .count    (count_q),
    .rdata_q  (bus_rdata),
    .shadow_q (shadow_q)
  );
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int BUS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_down,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_sel,
  input logic               run_q,
  input logic [2*BUS_W-1:0] count_q,
  input logic [BUS_W-1:0]   shadow_q,
  input logic [BUS_W-1:0]   bus_rdata
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (count_q == '0));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !pwr_down) |=> (count_q == $past(count_q) + 1'b1));

  assert_arm_on_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && !pwr_down) |=> run_q);

  assert_sticky_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !pwr_down) |=> run_q);

  assert_high_write_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pwr_down && !(bus_wr && !bus_sel)) |=> !run_q);

  assert_pwr_down_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!run_q && count_q == '0));

  assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_sel) |=> (shadow_q == $past(count_q[2*BUS_W-1:BUS_W])));

  assert_high_from_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel) |=> (bus_rdata == $past(shadow_q)));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind cycle_stamp_counter cs_checker #(.BUS_W(BUS_W)) u_cs_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pwr_down  (pwr_down),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sel   (bus_sel),
  .run_q     (run_q),
  .count_q   (count_q),
  .shadow_q  (shadow_q),
  .bus_rdata (bus_rdata)
);

// File: tb/cycle_stamp_counter_bench.sv
`timescale 1ns/1ps
module cycle_stamp_counter_bench;
  localparam int BW = 8;
  localparam int CW = 2 * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_down = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_sel = 1'b0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_tag = "R1";

  typedef struct {
    logic [BW-1:0] value;
    string         tag;
  } exp_item_t;

  exp_item_t     exp_q[$];
  bit            rd_due = 0;
  logic [BW-1:0] last_exp = '0;

  logic          m_run = 0;
  logic [CW-1:0] m_cnt = '0;
  logic [BW-1:0] m_shadow = '0;

  always #2 clk = ~clk;

  cycle_stamp_counter #(.BUS_W(BW), .SEG_W(4)) u_cycle_stamp_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: queues the expected read result, then advances its count.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = '0; m_shadow = '0; rd_due = 0;
    end else begin
      rd_due = bus_rd;
      if (bus_rd) begin
        exp_item_t it;
        if (!bus_sel) begin
          it.value = m_cnt[BW-1:0];
          m_shadow = m_cnt[CW-1:BW];
        end else begin
          it.value = m_shadow;
        end
        it.tag = cur_tag;
        exp_q.push_back(it);
      end
      if (pwr_down) begin
        m_run = 0; m_cnt = '0;
      end else begin
        m_cnt = m_run ? m_cnt + 1'b1 : '0;
        if (bus_wr && !bus_sel) m_run = 1;
      end
    end
  end

  // Monitor: compares each result half a cycle after it is due.
  always @(negedge clk) begin
    if (rd_due && rst_n) begin
      rd_due = 0;
      if (exp_q.size() == 0) begin
        check("R8 queue", 1, 0);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        last_exp = it.value;
        check(it.tag, bus_rdata, it.value);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
    end
  endtask

  task automatic do_wr(logic sel, logic [BW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic do_rd(logic sel);
    @(negedge clk);
    bus_rd = 1; bus_wr = 0; bus_sel = sel;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic reset_block();
    @(negedge clk);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(3);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    reset_block();
    check("R1 reset rdata", bus_rdata, '0);

    cur_tag = "R1";
    idle(20); do_rd(0); do_rd(1);

    cur_tag = "R5";
    do_wr(1, 8'hA5); idle(10); do_rd(0);

    cur_tag = "R2";
    @(negedge clk);
    bus_wr = 1; bus_sel = 0; bus_wdata = 8'h00;
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_sel = 0;
    @(negedge clk);
    bus_rd = 0;
    idle(7); do_rd(0); do_rd(0); do_rd(0);

    cur_tag = "R4";
    do_wr(0, 8'h3C); idle(2); do_rd(0);

    cur_tag = "R5";
    do_wr(1, 8'hFF); do_rd(0);

    cur_tag = "R7";
    idle(300); do_rd(0); idle(600); do_rd(1); do_rd(0); do_rd(1);

    cur_tag = "R8";
    idle(5);
    check("R8 hold", bus_rdata, last_exp);

    cur_tag = "R6";
    @(negedge clk);
    pwr_down = 1; bus_wr = 1; bus_sel = 0;
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_sel = 0;
    @(negedge clk);
    bus_rd = 0;
    idle(4);
    pwr_down = 0;
    idle(5); do_rd(0);
    do_wr(0, 8'hFF); idle(3); do_rd(0); do_rd(1);

    cur_tag = "R3";
    idle(40); do_rd(0);

    cur_tag = "R10";
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R10 async clear", bus_rdata, '0);
    idle(2);
    rst_n = 1;
    idle(3);
    do_rd(0); do_rd(1);

    cur_tag = "R9";
    do_wr(0, 8'h12);
    idle(65520);
    for (int k = 0; k < 12; k++) begin
      do_rd(0); do_rd(1);
    end
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule